// File: doc/BRIEF.md
# Internal Register Access Instruction Unit

This block executes four two-byte extended instructions that reach a small private register space, separate from the memory map. Two of the instructions move a 32-bit value between an operand and one internal register chosen by a 32-bit address operand. The other two return a BLT buffer pointer to that buffer's base. The block holds a base and a pointer for each of two BLT buffers, plus a power-management base and a power-management mask. The internal register addresses all lie at the top of the 32-bit address space.

The instruction decoder presents an already-decoded opcode with a valid strobe, together with the address and data operands and the 2-bit cache scratchpad-size configuration field. The block accepts one instruction per cycle. When the scratchpad-size field is zero, no part of the cache is scratchpad, so the block treats the graphics path as unused. In that case every one of the four instructions raises a one-cycle illegal-opcode trap and does nothing else.

Each buffer has an increment strobe that stands in for the blitter stepping through its buffer. The current pointers are driven out continuously. Read results are valid for one cycle, one clock after the instruction is issued.

Top module: `irau_top`

## Requirements
- R1: After reset, every internal register and both pointers are zero, and `trap` and `rd_valid` are low.
- R2: The opcode encoding is 2'b00 pointer-0 reset, 2'b01 pointer-1 reset, 2'b10 write, 2'b11 read. A write issued in cycle N stores `data_opnd` at the clock edge that ends cycle N+1. A read issued in cycle N drives `rd_valid` high and the selected register value on `rd_data` during cycle N+1. The register addresses are FFFFFF0Ch for base 0, FFFFFF1Ch for base 1, FFFFFF2Ch for pointer 0, FFFFFF3Ch for pointer 1, FFFFFF6Ch for the power-management base and FFFFFF7Ch for the power-management mask.
- R3: Buffer base and pointer registers are 12 bits wide. A write keeps `data_opnd[11:0]` and discards the upper bits. A read returns the value zero-extended to 32 bits.
- R4: The power-management base and mask registers store and return all 32 bits.
- R5: A pointer-reset instruction loads that buffer's pointer with its base. The load happens at the edge that ends the cycle after issue.
- R6: An `inc` strobe sampled at a clock edge adds 4 to that buffer's pointer, modulo 4096.
- R7: When a pointer reset executes at the same edge as the matching `inc` strobe, the pointer takes the base.
- R8: When `spad_size` is 2'b00 at issue, `trap` is high for exactly the next cycle, `rd_valid` stays low, and no register changes. Any nonzero `spad_size` enables the instructions and gives no trap.
- R9: An address outside the map causes no trap. A read of it returns zero with `rd_valid` high, and a write to it changes no register. This includes any address with bit 31 clear.
- R10: When a write to a pointer executes at the same edge as that buffer's `inc` strobe, the pointer takes the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A decoded instruction is present this cycle |
| op_code | input | 2 | Decoded instruction (see R2) |
| addr_opnd | input | 32 | Internal register address operand |
| data_opnd | input | 32 | Write data operand |
| spad_size | input | 2 | Cache scratchpad-size field; 00 disables the instructions |
| inc | input | 2 | Per-buffer pointer advance strobe, bit b for buffer b |
| rd_data | output | 32 | Read result, zero when `rd_valid` is low |
| rd_valid | output | 1 | Read result valid |
| trap | output | 1 | Illegal-opcode trap pulse |
| ptr0 | output | 12 | Current BLT buffer 0 pointer |
| ptr1 | output | 12 | Current BLT buffer 1 pointer |

## Verification
The hardest cases to create from the ports are the collisions between a pointer-changing instruction and the increment strobe. An instruction only acts one cycle after it is issued, so a strobe raised together with the instruction misses it. The stimulus therefore issues the pointer reset or pointer write, and raises `inc` in the following cycle, so that both meet on the same edge. The disabled case is checked for side effects by reading back, with the field enabled again, the register that the trapped write or the trapped reset would have changed.

// File: rtl/irau_pkg.sv
package irau_pkg;

    localparam int DATA_W   = 32;
    localparam int BUF_AW   = 12;
    localparam int NUM_BUF  = 2;
    localparam int NUM_REG  = 2 * NUM_BUF + 2;
    localparam int PTR_STEP = 4;

    typedef enum logic [1:0] {
        OP_PRST0 = 2'b00,
        OP_PRST1 = 2'b01,
        OP_WRITE = 2'b10,
        OP_READ  = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRST0,
        ST_PRST1,
        ST_WRITE,
        ST_READ,
        ST_FAULT
    } st_e;

    // Register index: 0..NUM_BUF-1 bases, then pointers, then PM base, PM mask.
    function automatic logic [DATA_W-1:0] reg_addr(input int idx);
        logic [3:0] code;
        code = (idx < 2 * NUM_BUF) ? 4'(idx) : 4'(idx + 2);
        return {24'hFFFFFF, code, 4'hC};
    endfunction

endpackage

// File: rtl/irau_addr_dec.sv
module irau_addr_dec
    import irau_pkg::*;
(
    input  logic [DATA_W-1:0]  addr,
    output logic [NUM_REG-1:0] sel
);

    for (genvar i = 0; i < NUM_REG; i++) begin : g_match
        assign sel[i] = (addr == reg_addr(i));
    end

endmodule

// File: rtl/irau_ctrl.sv
module irau_ctrl
    import irau_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_code,
    input  logic [DATA_W-1:0] addr_opnd,
    input  logic [DATA_W-1:0] data_opnd,
    input  logic [1:0]        spad_size,
    output st_e               st,
    output logic [DATA_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic              wr_en,
    output logic              rd_en,
    output logic [NUM_BUF-1:0] prst,
    output logic              trap
);

    st_e st_nxt;
    logic enabled;

    assign enabled = (spad_size != 2'b00);

    always_comb begin
        if (!op_valid) begin
            st_nxt = ST_IDLE;
        end else if (!enabled) begin
            st_nxt = ST_FAULT;
        end else begin
            unique case (op_e'(op_code))
                OP_PRST0: st_nxt = ST_PRST0;
                OP_PRST1: st_nxt = ST_PRST1;
                OP_WRITE: st_nxt = ST_WRITE;
                OP_READ:  st_nxt = ST_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            st <= st_nxt;
            if (op_valid) begin
                addr_q <= addr_opnd;
                data_q <= data_opnd;
            end
        end
    end

    always_comb begin
        wr_en = 1'b0;
        rd_en = 1'b0;
        prst  = '0;
        trap  = 1'b0;
        unique case (st)
            ST_IDLE:  ;
            ST_PRST0: prst[0] = 1'b1;
            ST_PRST1: prst[1] = 1'b1;
            ST_WRITE: wr_en   = 1'b1;
            ST_READ:  rd_en   = 1'b1;
            ST_FAULT: trap    = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/irau_regs.sv
module irau_regs
    import irau_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [NUM_REG-1:0]              sel,
    input  logic [DATA_W-1:0]               wdata,
    input  logic [NUM_BUF-1:0]              prst,
    input  logic [NUM_BUF-1:0]              inc,
    output logic [DATA_W-1:0]               rdata,
    output logic [NUM_BUF-1:0][BUF_AW-1:0]  base,
    output logic [NUM_BUF-1:0][BUF_AW-1:0]  ptr
);

    localparam int PM_BASE_IDX = 2 * NUM_BUF;
    localparam int PM_MASK_IDX = 2 * NUM_BUF + 1;

    logic [DATA_W-1:0] pm_base;
    logic [DATA_W-1:0] pm_mask;
    logic [NUM_REG-1:0][DATA_W-1:0] view;

    for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base[b] <= '0;
            end else if (wr_en && sel[b]) begin
                base[b] <= wdata[BUF_AW-1:0];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr[b] <= '0;
            end else if (prst[b]) begin
                ptr[b] <= base[b];
            end else if (wr_en && sel[NUM_BUF + b]) begin
                ptr[b] <= wdata[BUF_AW-1:0];
            end else if (inc[b]) begin
                ptr[b] <= ptr[b] + BUF_AW'(PTR_STEP);
            end
        end

        assign view[b]           = DATA_W'(base[b]);
        assign view[NUM_BUF + b] = DATA_W'(ptr[b]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pm_base <= '0;
            pm_mask <= '0;
        end else if (wr_en) begin
            if (sel[PM_BASE_IDX]) pm_base <= wdata;
            if (sel[PM_MASK_IDX]) pm_mask <= wdata;
        end
    end

    assign view[PM_BASE_IDX] = pm_base;
    assign view[PM_MASK_IDX] = pm_mask;

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REG; i++) begin
            if (sel[i]) rdata = view[i];
        end
    end

endmodule

// File: rtl/irau_top.sv
module irau_top
    import irau_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_code,
    input  logic [31:0]       addr_opnd,
    input  logic [31:0]       data_opnd,
    input  logic [1:0]        spad_size,
    input  logic [1:0]        inc,
    output logic [31:0]       rd_data,
    output logic              rd_valid,
    output logic              trap,
    output logic [11:0]       ptr0,
    output logic [11:0]       ptr1
);

    st_e                            st;
    logic [DATA_W-1:0]              addr_q;
    logic [DATA_W-1:0]              data_q;
    logic                           wr_en;
    logic                           rd_en;
    logic [NUM_BUF-1:0]             prst;
    logic [NUM_REG-1:0]             sel;
    logic [DATA_W-1:0]              rdata;
    logic [NUM_BUF-1:0][BUF_AW-1:0] base_w;
    logic [NUM_BUF-1:0][BUF_AW-1:0] ptr_w;

    irau_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .addr_opnd (addr_opnd),
        .data_opnd (data_opnd),
        .spad_size (spad_size),
        .st        (st),
        .addr_q    (addr_q),
        .data_q    (data_q),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .prst      (prst),
        .trap      (trap)
    );

    irau_addr_dec u_dec (
        .addr (addr_q),
        .sel  (sel)
    );

    irau_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .sel   (sel),
        .wdata (data_q),
        .prst  (prst),
        .inc   (inc),
        .rdata (rdata),
        .base  (base_w),
        .ptr   (ptr_w)
    );

    assign rd_valid = rd_en;
    assign rd_data  = rd_en ? rdata : '0;
    assign ptr0     = ptr_w[0];
    assign ptr1     = ptr_w[1];

endmodule

// File: rtl/irau_chk.sv
module irau_chk
    import irau_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [1:0]  op_code,
    input logic [1:0]  spad_size,
    input logic [1:0]  inc,
    input logic        rd_valid,
    input logic        trap,
    input logic [11:0] ptr0,
    input logic [11:0] base0,
    input st_e         st
);

    assert_one_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, trap}));

    assert_read_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && spad_size != 2'b00 && op_code == 2'b11) |=> rd_valid);

    assert_ptr_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PRST0) |=> (ptr0 == $past(base0)));

    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc[0] && st == ST_IDLE) |=> (ptr0 == $past(ptr0) + 12'd4));

    assert_trap_raised_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && spad_size == 2'b00) |=> (trap && !rd_valid));

    assert_no_trap_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || spad_size != 2'b00) |=> !trap);

    assert_trap_keeps_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trap && !inc[0]) |=> $stable(ptr0));

endmodule

bind irau_top irau_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .spad_size (spad_size),
    .inc       (inc),
    .rd_valid  (rd_valid),
    .trap      (trap),
    .ptr0      (ptr0),
    .base0     (base_w[0]),
    .st        (st)
);

// File: tb/sim_irau_top.sv
module sim_irau_top;

    localparam int CLK_PERIOD = 10;

    localparam logic [31:0] A_B0B = 32'hFFFFFF0C;
    localparam logic [31:0] A_B1B = 32'hFFFFFF1C;
    localparam logic [31:0] A_B0P = 32'hFFFFFF2C;
    localparam logic [31:0] A_B1P = 32'hFFFFFF3C;
    localparam logic [31:0] A_PMB = 32'hFFFFFF6C;
    localparam logic [31:0] A_PMM = 32'hFFFFFF7C;
    localparam logic [31:0] A_GAP = 32'hFFFFFF4C;
    localparam logic [31:0] A_LOW = 32'h7FFFFF0C;

    localparam logic [1:0] P0 = 2'b00, P1 = 2'b01, WR = 2'b10, RD = 2'b11;

    typedef struct packed {
        logic        v;
        logic [1:0]  op;
        logic [31:0] addr;
        logic [31:0] data;
        logic [1:0]  spad;
        logic        ev;
        logic        et;
        logic [31:0] ed;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 22;
    localparam vec_t TBL [NVEC] = '{
        '{1'b1, WR, A_B0B, 32'hABCDE123, 2'd1, 1'b0, 1'b0, 32'h0,        4'd2},
        '{1'b1, RD, A_B0B, 32'h0,        2'd1, 1'b1, 1'b0, 32'h00000123, 4'd3},  // R3
        '{1'b1, WR, A_PMB, 32'hDEADBEEF, 2'd2, 1'b0, 1'b0, 32'h0,        4'd4},
        '{1'b1, RD, A_PMB, 32'h0,        2'd2, 1'b1, 1'b0, 32'hDEADBEEF, 4'd4},  // R4
        '{1'b1, WR, A_PMM, 32'h0F0F00FF, 2'd3, 1'b0, 1'b0, 32'h0,        4'd4},
        '{1'b1, RD, A_PMM, 32'h0,        2'd3, 1'b1, 1'b0, 32'h0F0F00FF, 4'd4},  // R4
        '{1'b1, WR, A_B1B, 32'h00000FFC, 2'd1, 1'b0, 1'b0, 32'h0,        4'd2},
        '{1'b1, RD, A_B1B, 32'h0,        2'd1, 1'b1, 1'b0, 32'h00000FFC, 4'd2},  // R2
        '{1'b1, P1,  32'h0, 32'h0,       2'd1, 1'b0, 1'b0, 32'h0,        4'd5},
        '{1'b1, RD, A_B1P, 32'h0,        2'd1, 1'b1, 1'b0, 32'h00000FFC, 4'd5},  // R5
        '{1'b1, RD, A_GAP, 32'h0,        2'd1, 1'b1, 1'b0, 32'h0,        4'd9},  // R9
        '{1'b1, WR, A_GAP, 32'h12345678, 2'd1, 1'b0, 1'b0, 32'h0,        4'd9},
        '{1'b1, RD, A_PMM, 32'h0,        2'd1, 1'b1, 1'b0, 32'h0F0F00FF, 4'd9},  // R9
        '{1'b1, RD, A_B0B, 32'h0,        2'd0, 1'b0, 1'b1, 32'h0,        4'd8},  // R8
        '{1'b1, WR, A_B0B, 32'h00000777, 2'd0, 1'b0, 1'b1, 32'h0,        4'd8},
        '{1'b1, RD, A_B0B, 32'h0,        2'd1, 1'b1, 1'b0, 32'h00000123, 4'd8},  // R8
        '{1'b1, WR, A_B0P, 32'hFFFF0550, 2'd1, 1'b0, 1'b0, 32'h0,        4'd3},
        '{1'b1, RD, A_B0P, 32'h0,        2'd1, 1'b1, 1'b0, 32'h00000550, 4'd3},  // R3
        '{1'b1, RD, A_LOW, 32'h0,        2'd1, 1'b1, 1'b0, 32'h0,        4'd9},  // R9
        '{1'b0, RD, A_B0B, 32'h0,        2'd1, 1'b0, 1'b0, 32'h0,        4'd2},  // R2
        '{1'b1, P0,  32'h0, 32'h0,       2'd0, 1'b0, 1'b1, 32'h0,        4'd8},
        '{1'b1, RD, A_B0P, 32'h0,        2'd1, 1'b1, 1'b0, 32'h00000550, 4'd8}   // R8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'b00;
    logic [31:0] addr_opnd = '0;
    logic [31:0] data_opnd = '0;
    logic [1:0]  spad_size = 2'b01;
    logic [1:0]  inc = 2'b00;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        trap;
    logic [11:0] ptr0;
    logic [11:0] ptr1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irau_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .addr_opnd (addr_opnd),
        .data_opnd (data_opnd),
        .spad_size (spad_size),
        .inc       (inc),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .trap      (trap),
        .ptr0      (ptr0),
        .ptr1      (ptr1)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive at the falling edge, let the rising edge capture, then sample just after it.
    task automatic step(input logic v, input logic [1:0] op, input logic [31:0] a,
                        input logic [31:0] d, input logic [1:0] sp, input logic [1:0] in);
        @(negedge clk);
        op_valid  = v;
        op_code   = op;
        addr_opnd = a;
        data_opnd = d;
        spad_size = sp;
        inc       = in;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input logic [1:0] in);
        step(1'b0, RD, 32'h0, 32'h0, 2'd1, in);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1", "ptr0", 32'(ptr0), 32'h0);
        check("R1", "ptr1", 32'(ptr1), 32'h0);
        check("R1", "trap", 32'(trap), 32'h0);
        check("R1", "rd_valid", 32'(rd_valid), 32'h0);
        step(1'b1, RD, A_PMM, 32'h0, 2'd1, 2'b00);
        check("R1", "pm mask after reset", rd_data, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            step(TBL[i].v, TBL[i].op, TBL[i].addr, TBL[i].data, TBL[i].spad, 2'b00);
            check($sformatf("R%0d", TBL[i].req), $sformatf("vec %0d trap", i),
                  32'(trap), 32'(TBL[i].et));
            check($sformatf("R%0d", TBL[i].req), $sformatf("vec %0d rd_valid", i),
                  32'(rd_valid), 32'(TBL[i].ev));
            if (TBL[i].ev)
                check($sformatf("R%0d", TBL[i].req), $sformatf("vec %0d rd_data", i),
                      rd_data, TBL[i].ed);
        end
        idle(2'b00);

        // R6: pointer 1 sits at FFC, step wraps to 000 then 004
        idle(2'b10);
        check("R6", "ptr1 wrap", 32'(ptr1), 32'h000);
        idle(2'b10);
        check("R6", "ptr1 step", 32'(ptr1), 32'h004);
        check("R6", "ptr0 untouched", 32'(ptr0), 32'h550);

        // R7: reset executes on the same edge as inc[0]
        step(1'b1, P0, 32'h0, 32'h0, 2'd1, 2'b00);
        idle(2'b01);
        check("R7", "ptr0 reset wins", 32'(ptr0), 32'h123);

        // R10: pointer write executes on the same edge as inc[0]
        step(1'b1, WR, A_B0P, 32'h00000200, 2'd1, 2'b00);
        idle(2'b01);
        check("R10", "ptr0 write wins", 32'(ptr0), 32'h200);
        idle(2'b01);
        check("R6", "ptr0 step after write", 32'(ptr0), 32'h204);

        // R8: trap lasts one cycle only
        step(1'b1, RD, A_PMB, 32'h0, 2'd0, 2'b00);
        check("R8", "trap pulse", 32'(trap), 32'h1);
        idle(2'b00);
        check("R8", "trap drops", 32'(trap), 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule